// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 interrupt request lines and presents them to a processor through a small 32-bit register bus that allows byte-lane writes. Every source has a one-byte configuration entry. The entry turns the source on or off, chooses between active-high level sensing and edge sensing (rising, falling or both), and picks one of eight destinations. The destinations are the normal interrupt line, the fast interrupt line and six auxiliary lines.

Edge events are captured in sticky status bits, and software clears them by writing ones. A read-only index register names the source that should be serviced next among the pending sources routed to the normal interrupt line. The search uses either fixed lowest-number-first priority or rotating priority. Under rotating priority the search starts just above the last index that software read. When nothing is pending the index reads 63. Software tells a real source 63 apart from the idle value by looking at bit 31 of the upper status word.

Top module: `vec_intc`

## Requirements
- R1: After reset, all 64 configuration bytes read 0 (disabled, destination 0), both status words read 0, both priority registers read 0, the index register reads 63, and irqOut, fiqOut and auxOut are low.
- R2: Configuration byte for source i is byte lane i%4 of the word at offset 0x40+4*(i/4). Bits 2:0 hold the destination, bit 3 is the enable, bit 5 selects rising-edge sensing and bit 6 selects falling-edge sensing. Bits 4 and 7 read as 0. A write changes only the byte lanes whose busByteEn bit is set.
- R3: With bits 5 and 6 both 0, a source is active-high level sensitive. When the source is enabled and its input is high, it drives its destination output in the same cycle, with no register on the path. When the input is low it drives nothing.
- R4: A source with bit 5 set latches its status bit at the first clock edge at which its input is high after having been low at the previous edge. The latched bit then reads as 1 at bit i%32 of the status word at 0x80 (sources 0 to 31) or 0x84 (sources 32 to 63).
- R5: Writing a status word clears each latched bit whose data bit is 1 and whose byte lane is enabled. Bits written with 0 are unchanged. An edge detected in the same cycle as the clearing write wins, and the bit stays set.
- R6: A source whose enable bit is 0 never drives any output and never shows up in the index register. Its edge status bit still latches and can be read.
- R7: Destination code 0 drives irqOut and code 1 drives fiqOut. Codes 2 to 7 drive auxOut[0] to auxOut[5]. Each output is the OR of the enabled pending sources routed to it.
- R8: Reading offset 0x00 returns, in bits 5:0, the pending enabled source routed to destination 0 that wins priority, or 63 when there is none. With bit 6 of the register at 0x20 clear, the lowest-numbered such source wins. Sources routed elsewhere are never reported.
- R9: With bit 6 of the register at 0x20 set, the search starts at one above the last value read from offset 0x00 (63 after reset) and wraps from 63 to 0.
- R10: For a level-sensed source, its status bit reads its raw input. So with source 63 enabled, level sensed and high, bit 31 at 0x84 reads 1. The same bit reads 0 when the index shows the idle value 63.
- R11: The registers at 0x20 and 0x24 read back bits 6:0 as written through byte lane 0, and their other bits read 0. Writes to offset 0x00, to unmapped offsets and to addresses with nonzero bits 1:0 change nothing. Reads of those unmapped or misaligned addresses return 0.
- R12: A source with bit 6 set latches on a high-to-low input change. With bits 5 and 6 both set, it latches on either change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; a strobed read of 0x00 advances the rotation point |
| busByteEn | input | 4 | Byte-lane enables for writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| srcIn | input | 64 | Interrupt source lines |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| auxOut | output | 6 | Auxiliary destination lines |

## Verification
Read data, level-driven outputs and the index value are combinational, so they are due in the same cycle as the address or input change. Register writes, edge captures and the rotation point take effect at the first rising clock edge after the stimulus. The bench therefore changes inputs and starts bus accesses on falling edges. It samples combinational results a moment later. It samples results that pass through a register only after a rising edge has gone by, and it compares both against a bench-side model of latches, masks and the wrap-around priority search.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam int LANES  = BUS_DW / 8;

  // register offsets (byte addresses)
  localparam int OFS_INDEX    = 'h00;
  localparam int OFS_PRIO_IRQ = 'h20;
  localparam int OFS_PRIO_FIQ = 'h24;
  localparam int OFS_CTRL     = 'h40;
  localparam int OFS_STATUS   = 'h80;

  // configuration byte layout
  localparam int CB_DEST_LSB = 0;
  localparam int CB_DEST_W   = 3;
  localparam int CB_EN       = 3;
  localparam int CB_RISE     = 5;
  localparam int CB_FALL     = 6;
  localparam logic [7:0] CB_MASK = 8'h6F;

  // priority register layout
  localparam int PR_W   = 7;
  localparam int PR_ROT = 6;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_INDEX,
    RD_CTRL,
    RD_STATUS,
    RD_PRIO_IRQ,
    RD_PRIO_FIQ
  } rdSel_e;

  typedef struct packed {
    logic              ctrlWr;
    logic              stsClr;
    logic              prioIrqWr;
    logic              prioFiqWr;
    logic              idxRead;
    logic [LANES-1:0]  laneEn;
    logic [BUS_AW-3:0] wordIdx;
    rdSel_e            rdSel;
  } strobes_t;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] cand,
  input  logic               rotate,
  input  logic [IDX_W-1:0]   lastIdx,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] startIdx;
  logic [IDX_W-1:0] pos;

  // scan from the far end back toward the start so the nearest hit wins;
  // index arithmetic wraps because NUM_SRC is a power of two
  always_comb begin
    startIdx = rotate ? lastIdx + 1'b1 : '0;
    idx      = '1;
    pos      = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      pos = startIdx + IDX_W'(k);
      if (cand[pos]) idx = pos;
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [LANES-1:0]  busByteEn,
  output strobes_t          stb
);
  localparam int WIDX_W     = BUS_AW - 2;
  localparam int CTRL_BASE  = OFS_CTRL / LANES;
  localparam int CTRL_WORDS = NUM_SRC / LANES;
  localparam int STS_BASE   = OFS_STATUS / LANES;
  localparam int STS_WORDS  = NUM_SRC / BUS_DW;

  logic [WIDX_W-1:0] word;
  logic aligned, inIndex, inPrioIrq, inPrioFiq, inCtrl, inSts;

  assign word      = busAddr[BUS_AW-1:2];
  assign aligned   = (busAddr[1:0] == 2'b00);
  assign inIndex   = aligned && (word == WIDX_W'(OFS_INDEX / LANES));
  assign inPrioIrq = aligned && (word == WIDX_W'(OFS_PRIO_IRQ / LANES));
  assign inPrioFiq = aligned && (word == WIDX_W'(OFS_PRIO_FIQ / LANES));
  assign inCtrl    = aligned && (word >= WIDX_W'(CTRL_BASE))
                             && (word <  WIDX_W'(CTRL_BASE + CTRL_WORDS));
  assign inSts     = aligned && (word >= WIDX_W'(STS_BASE))
                             && (word <  WIDX_W'(STS_BASE + STS_WORDS));

  always_comb begin
    stb.ctrlWr    = busWrEn && inCtrl;
    stb.stsClr    = busWrEn && inSts;
    stb.prioIrqWr = busWrEn && inPrioIrq;
    stb.prioFiqWr = busWrEn && inPrioFiq;
    stb.idxRead   = busRdEn && inIndex;
    stb.laneEn    = busByteEn;
    stb.wordIdx   = inSts ? word - WIDX_W'(STS_BASE) : word - WIDX_W'(CTRL_BASE);
    if (inIndex)        stb.rdSel = RD_INDEX;
    else if (inCtrl)    stb.rdSel = RD_CTRL;
    else if (inSts)     stb.rdSel = RD_STATUS;
    else if (inPrioIrq) stb.rdSel = RD_PRIO_IRQ;
    else if (inPrioFiq) stb.rdSel = RD_PRIO_FIQ;
    else                stb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_AUX = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [BUS_DW-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [BUS_DW-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_AUX-1:0] auxOut
);
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int DEST_N     = NUM_AUX + 2;
  localparam int CTRL_WORDS = NUM_SRC / LANES;
  localparam int STS_WORDS  = NUM_SRC / BUS_DW;
  localparam int WIDX_W     = BUS_AW - 2;

  logic [NUM_SRC*8-1:0]         ctrlFlat;
  logic [NUM_SRC*CB_DEST_W-1:0] destFlat;
  logic [NUM_SRC-1:0] enBit, riseSel, fallSel, levelMode;
  logic [NUM_SRC-1:0] srcPrev, stsLatch, stsView, pending, irqCand;
  logic [DEST_N-1:0]  destHit;
  logic [IDX_W-1:0]   lastIdx, idxVal;
  logic [PR_W-1:0]    prioIrq, prioFiq;
  logic [BUS_DW-1:0]  ctrlWord, stsWord;

  // follows the inputs during reset too, so no false edge on release
  always_ff @(posedge clk) srcPrev <= srcIn;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int WORD  = i / LANES;
    localparam int LANE  = i % LANES;
    localparam int SWORD = i / BUS_DW;
    localparam int SBIT  = i % BUS_DW;

    logic [7:0] cfg;
    logic       latchQ, ctrlHit, clrHit, edgeSet;

    assign ctrlHit = stb.ctrlWr && (stb.wordIdx == WIDX_W'(WORD)) && stb.laneEn[LANE];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        cfg <= '0;
      else if (ctrlHit) cfg <= wrData[8*LANE +: 8] & CB_MASK;
    end

    assign ctrlFlat[8*i +: 8]                 = cfg;
    assign destFlat[CB_DEST_W*i +: CB_DEST_W] = cfg[CB_DEST_LSB +: CB_DEST_W];
    assign enBit[i]     = cfg[CB_EN];
    assign riseSel[i]   = cfg[CB_RISE];
    assign fallSel[i]   = cfg[CB_FALL];
    assign levelMode[i] = ~(cfg[CB_RISE] | cfg[CB_FALL]);

    assign edgeSet = (riseSel[i] &  srcIn[i] & ~srcPrev[i])
                   | (fallSel[i] & ~srcIn[i] &  srcPrev[i]);
    assign clrHit  = stb.stsClr && (stb.wordIdx == WIDX_W'(SWORD))
                   && stb.laneEn[SBIT/8] && wrData[SBIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             latchQ <= 1'b0;
      else if (levelMode[i]) latchQ <= 1'b0;
      else                   latchQ <= edgeSet | (latchQ & ~clrHit);
    end

    assign stsLatch[i] = latchQ;
    assign stsView[i]  = levelMode[i] ? srcIn[i] : latchQ;
    assign pending[i]  = enBit[i] & stsView[i];
    assign irqCand[i]  = pending[i] && (cfg[CB_DEST_LSB +: CB_DEST_W] == '0);

    // R4: a rising input in rising mode is captured by the next cycle
    a_r4_rise_latches: assert property (@(posedge clk) disable iff (!rstN)
      (riseSel[i] && $rose(srcIn[i])) |=> stsLatch[i]);
    // R12: a falling input in falling mode is captured by the next cycle
    a_r12_fall_latches: assert property (@(posedge clk) disable iff (!rstN)
      (fallSel[i] && $fell(srcIn[i])) |=> stsLatch[i]);
    // R5: a clearing write with no competing edge empties the bit
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit && !(riseSel[i] && $rose(srcIn[i])) && !(fallSel[i] && $fell(srcIn[i])))
      |=> !stsLatch[i]);
  end

  // destination fan-in
  always_comb begin
    destHit = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int d = 0; d < DEST_N; d++) begin
        if (pending[i] && (destFlat[CB_DEST_W*i +: CB_DEST_W] == CB_DEST_W'(d)))
          destHit[d] = 1'b1;
      end
    end
  end

  assign irqOut = destHit[0];
  assign fiqOut = destHit[1];
  assign auxOut = destHit[DEST_N-1:2];

  vic_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_pick (
    .cand    (irqCand),
    .rotate  (prioIrq[PR_ROT]),
    .lastIdx (lastIdx),
    .idx     (idxVal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIdx <= '1;
      prioIrq <= '0;
      prioFiq <= '0;
    end else begin
      if (stb.idxRead) lastIdx <= idxVal;
      if (stb.prioIrqWr && stb.laneEn[0]) prioIrq <= wrData[PR_W-1:0];
      if (stb.prioFiqWr && stb.laneEn[0]) prioFiq <= wrData[PR_W-1:0];
    end
  end

  always_comb begin
    ctrlWord = '0;
    for (int w = 0; w < CTRL_WORDS; w++)
      if (stb.wordIdx == WIDX_W'(w)) ctrlWord = ctrlFlat[w*BUS_DW +: BUS_DW];
    stsWord = '0;
    for (int w = 0; w < STS_WORDS; w++)
      if (stb.wordIdx == WIDX_W'(w)) stsWord = stsView[w*BUS_DW +: BUS_DW];
  end

  always_comb begin
    case (stb.rdSel)
      RD_INDEX:    rdData = BUS_DW'(idxVal);
      RD_CTRL:     rdData = ctrlWord;
      RD_STATUS:   rdData = stsWord;
      RD_PRIO_IRQ: rdData = BUS_DW'(prioIrq);
      RD_PRIO_FIQ: rdData = BUS_DW'(prioFiq);
      default:     rdData = '0;
    endcase
  end

  // R8: a non-idle index means the irq line is up
  a_r8_index_implies_irq: assert property (@(posedge clk) disable iff (!rstN)
    (idxVal != '1) |-> irqOut);
  // R8: with the irq line down the index shows the idle value
  a_r8_idle_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (idxVal == '1));
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NUM_SRC = 64,
  parameter int NUM_AUX = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [3:0]         busByteEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_AUX-1:0] auxOut
);
  vic_pkg::strobes_t stb;

  vic_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busByteEn (busByteEn),
    .stb       (stb)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .NUM_AUX(NUM_AUX)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .srcIn  (srcIn),
    .rdData (busRdData),
    .irqOut (irqOut),
    .fiqOut (fiqOut),
    .auxOut (auxOut)
  );
endmodule

// File: tb/test_vec_intc.sv
module test_vec_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] srcIn = '0;
  logic        irqOut, fiqOut;
  logic [5:0]  auxOut;

  always #10 clk = ~clk;

  vec_intc i_vec_intc (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRdData(busRdData),
    .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut), .auxOut(auxOut)
  );

  int checks = 0;
  int errors = 0;
  bit rotOn = 1'b0;
  logic [5:0]  lastRd = 6'd63;
  logic [7:0]  ctrlExp [64];
  logic [31:0] rv, word0;
  logic [63:0] pat, cur, latchM, riseM, fallM, enM;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [5:0] expIdx(input logic [63:0] c, input bit rot, input logic [5:0] last);
    logic [5:0] s;
    logic [5:0] q;
    s = rot ? last + 6'd1 : 6'd0;
    for (int k = 0; k < 64; k++) begin
      q = s + 6'(k);
      if (c[q]) return q;
    end
    return 6'd63;
  endfunction

  task automatic rdIdx(input string req, input logic [63:0] cand);
    logic [31:0] d;
    logic [5:0]  e;
    e = expIdx(cand, rotOn, lastRd);
    rd(8'h00, d);
    chk(req, d, {26'b0, e});
    lastRd = e;
  endtask

  function automatic logic [63:0] nextPat(input logic [63:0] p);
    logic [63:0] x;
    x = p;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // move the sources to a new value and let one rising edge pass
  task automatic stepTo(input logic [63:0] nxt);
    latchM = latchM | (nxt & ~cur & riseM) | (~nxt & cur & fallM);
    cur = nxt;
    srcIn = nxt;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int w = 0; w < 16; w++) begin
      rd(8'h40 + 8'(4 * w), rv);
      chk("R1 ctrl word", rv, 32'h0);
    end
    rd(8'h80, rv); chk("R1 status lo", rv, 32'h0);
    rd(8'h84, rv); chk("R1 status hi", rv, 32'h0);
    rd(8'h20, rv); chk("R1 prio irq", rv, 32'h0);
    rd(8'h24, rv); chk("R1 prio fiq", rv, 32'h0);
    chk("R1 outputs", {24'b0, auxOut, fiqOut, irqOut}, 32'h0);
    rdIdx("R1 idle index", 64'h0);

    // R2 single-lane writes with junk on other lanes
    for (int i = 0; i < 64; i++) begin
      logic [7:0]  v;
      logic [31:0] d;
      v = 8'(i * 29 + 7);
      d = 32'hFFFF_FFFF;
      d[8*(i%4) +: 8] = v;
      wr(8'h40 + 8'(4 * (i / 4)), d, 4'b0001 << (i % 4));
      ctrlExp[i] = v & 8'h6F;
    end
    for (int w = 0; w < 16; w++) begin
      rd(8'h40 + 8'(4 * w), rv);
      chk("R2 byte layout", rv, {ctrlExp[4*w+3], ctrlExp[4*w+2], ctrlExp[4*w+1], ctrlExp[4*w]});
    end
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4 * w), 32'h0, 4'hF);

    // R7 routing of every destination code, R3 level sensing
    for (int d = 0; d < 8; d++) begin
      int s;
      s = d * 8 + 3;
      wr(8'h40 + 8'(4 * (s / 4)), 32'(8'h08 | 8'(d)) << (8 * (s % 4)), 4'b0001 << (s % 4));
      srcIn = 64'h1 << s;
      #1 chk("R7 R3 route", {24'b0, auxOut, fiqOut, irqOut}, 32'h1 << d);
      rdIdx("R8 only irq routed", (d == 0) ? (64'h1 << s) : 64'h0);
      srcIn = '0;
      #1 chk("R3 level low", {24'b0, auxOut, fiqOut, irqOut}, 32'h0);
      wr(8'h40 + 8'(4 * (s / 4)), 32'h0, 4'hF);
    end

    // R8 fixed priority over many patterns
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4 * w), 32'h0808_0808, 4'hF);
    pat = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 40; n++) begin
      logic [63:0] p;
      pat = nextPat(pat);
      p = pat & nextPat(pat);
      if (n == 0) p = 64'h0;
      if (n == 1) p = 64'h1;
      if (n == 2) p = 64'h8000_0000_0000_0000;
      srcIn = p;
      #1 chk("R8 irq line", {31'b0, irqOut}, {31'b0, |p});
      rdIdx("R8 fixed index", p);
    end

    // R11 write to the index register is ignored
    srcIn = 64'h0000_0100_0000_0000;
    wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    rdIdx("R11 index write ignored", srcIn);
    rd(8'h20, rv); chk("R11 prio unchanged", rv, 32'h0);

    // R10 source 63 against the idle value
    srcIn = 64'h8000_0000_0000_0000;
    rdIdx("R10 real 63", srcIn);
    rd(8'h84, rv); chk("R10 bit31 set", rv, 32'h8000_0000);
    srcIn = '0;
    rdIdx("R10 idle 63", 64'h0);
    rd(8'h84, rv); chk("R10 bit31 clear", rv, 32'h0);

    // R9 rotating priority
    wr(8'h20, 32'h0000_0040, 4'h1);
    rotOn = 1'b1;
    for (int n = 0; n < 16; n++) begin
      logic [63:0] p;
      pat = nextPat(pat);
      p = pat & nextPat(pat) & nextPat(nextPat(pat));
      if (n == 0) p = 64'h8000_0000_0000_0000;
      if (n == 1) p = 64'h1000_0000_0000_0004;
      srcIn = p;
      for (int r = 0; r < 3; r++) rdIdx("R9 rotating index", p);
    end
    srcIn = '0;

    // R11 priority registers
    rd(8'h20, rv); chk("R11 prio irq readback", rv, 32'h40);
    wr(8'h24, 32'hFFFF_FFFF, 4'hF);
    rd(8'h24, rv); chk("R11 prio fiq readback", rv, 32'h7F);
    wr(8'h24, 32'h0, 4'b1110);
    rd(8'h24, rv); chk("R11 lane0 only", rv, 32'h7F);
    wr(8'h20, 32'h0, 4'hF);
    rotOn = 1'b0;
    rd(8'h20, rv); chk("R11 back to fixed", rv, 32'h0);

    // R4 R12 R5 edge capture
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4 * w), 32'h0, 4'hF);
    riseM = '0; fallM = '0; enM = '0;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] d;
      for (int l = 0; l < 4; l++) begin
        int i;
        logic [7:0] b;
        i = 4 * w + l;
        b = (i % 3 == 0) ? 8'h28 : (i % 3 == 1) ? 8'h48 : 8'h68;
        d[8*l +: 8] = b;
        riseM[i] = (i % 3 != 1);
        fallM[i] = (i % 3 != 0);
        enM[i]   = 1'b1;
      end
      if (w == 0) word0 = d;
      wr(8'h40 + 8'(4 * w), d, 4'hF);
    end
    wr(8'h54, 32'h0000_0020, 4'h1);
    riseM[20] = 1'b1;
    latchM = '0;
    cur = '0;
    for (int n = 0; n < 14; n++) begin
      pat = nextPat(pat);
      latchM = latchM | ((pat[63:0] & 64'h0010_FFFF) & ~cur & riseM)
                      | (~(pat & 64'h0010_FFFF) & cur & fallM);
      cur = pat & 64'h0010_FFFF;
      srcIn = cur;
      rd(8'h80, rv);
      chk("R4 R12 edge status", rv, latchM[31:0]);
      #1 chk("R6 irq from enabled latches", {31'b0, irqOut}, {31'b0, |(latchM & enM)});
      rdIdx("R8 edge index", latchM & enM);
      if (n % 4 == 3) begin
        logic [31:0] m;
        logic [3:0]  be;
        logic [31:0] eff;
        m = nextPat(pat)[31:0];
        be = (n % 8 == 3) ? 4'b0011 : 4'b1101;
        eff = m & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        wr(8'h80, m, be);
        latchM[31:0] = latchM[31:0] & ~eff;
        rd(8'h80, rv);
        chk("R5 write-one clear", rv, latchM[31:0]);
      end
    end

    // R6 disabled source still latches, drives nothing
    wr(8'h80, 32'hFFFF_FFFF, 4'hF);
    latchM = '0;
    stepTo(cur & ~64'h0010_0000);
    wr(8'h80, 32'hFFFF_FFFF, 4'hF);
    latchM = '0;
    stepTo(cur | 64'h0010_0000);
    rd(8'h80, rv); chk("R6 disabled status", rv, 32'h0010_0000);
    #1 chk("R6 disabled no irq", {31'b0, irqOut}, 32'h0);
    rdIdx("R6 disabled no index", 64'h0);

    // R5 edge wins over a clear in the same cycle
    stepTo(cur & ~64'h1);
    wr(8'h80, 32'hFFFF_FFFF, 4'hF);
    latchM = '0;
    @(negedge clk);
    busAddr = 8'h80; busWrData = 32'h1; busByteEn = 4'hF; busWrEn = 1'b1;
    srcIn = cur | 64'h1;
    @(negedge clk);
    busWrEn = 1'b0;
    cur = cur | 64'h1;
    rd(8'h80, rv); chk("R5 edge beats clear", rv, 32'h1);

    // R11 unmapped and misaligned accesses
    rd(8'h41, rv); chk("R11 misaligned read", rv, 32'h0);
    rd(8'h90, rv); chk("R11 unmapped read", rv, 32'h0);
    rd(8'h30, rv); chk("R11 gap read", rv, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);
    wr(8'h88, 32'hFFFF_FFFF, 4'hF);
    wr(8'h41, 32'hFFFF_FFFF, 4'hF);
    rd(8'h40, rv); chk("R11 ignored writes", rv, word0);
    rd(8'h80, rv); chk("R11 status untouched", rv, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule